// File: doc/BRIEF.md
# Serial EEPROM word reader

This block is a hardware master for a three-wire serial EEPROM of the Microwire kind. A single `start` pulse fetches one 16-bit word. The block drives chip select, the shift clock and the serial data line into the memory, and it samples the memory's serial data output. Before it starts, it latches the requested word address, the address width (6 or 8 bits) and a clock divider. From then on it runs the whole frame by itself: a select preamble, then the read command, then sixteen data clocks, then deselect. When the frame is over it reports the word together with a one-cycle `done` pulse.

The read command is a single word: a start bit, the read opcode and the address, shifted out MSB first with two leading zero bits. Its total length is 5 plus the address width. The memory side sees the data line change only while the shift clock is low.

An optional detection mode works out the address width on its own. It first reads word 0 with an 8-bit address. If that word equals a signature value, the 8-bit width is used, and otherwise the 6-bit width is used. It then reads the requested word with the chosen width and reports the width on `width8`.

Top module: `ee_word_reader`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done`, `width8` are low and `rdata` is zero.
- R2: While chip select is high, the command is sent MSB first as 5+W bits with the value (6 << W) | address, where W is the address width. The bits are two zeros, then 1, 1, 0, then the address. Each bit is placed on `ee_di` while `ee_sk` is low and stays there while `ee_sk` is high. The memory sees exactly 5+W+16 rising clock edges per frame.
- R3: After the command, the clock stays low for one phase. Then there are 16 clock pulses. `ee_do` is sampled at the end of each high phase, and the bits are assembled MSB first into `rdata`.
- R4: `wide`=1 selects an 8-bit address. `wide`=0 selects a 6-bit address, using `addr[5:0]` only, so `addr[7:6]` have no effect.
- R5: With `detect`=1, a first frame reads word 0 using an 8-bit address. The width is 8 if that word is 16'h8129 and 6 otherwise. A second frame then reads `addr` at that width, and `width8` reports the chosen width when `done` pulses.
- R6: Every phase (clock low, clock high, preamble, gap, deselect) lasts `div`+1 cycles. `busy` is high for (`div`+1)·(46+2W) cycles per frame, with the frames summed in detection mode.
- R7: Each frame ends with a one-phase deselect. `ee_cs` is never high while `busy` is low.
- R8: A `start` pulse while `busy` is high is ignored. Changes to `addr`, `wide`, `detect` and `div` during a read do not alter its result or its length.
- R9: `done` is a one-cycle pulse in the first cycle in which `busy` is low. `rdata` changes only in that cycle and holds its value otherwise.
- R10: Each frame begins with one phase in which `busy` is high and `ee_cs` is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request one word read (used only when idle) |
| addr | input | 8 | Word address; only the low 6 bits are used in narrow mode |
| wide | input | 1 | 1 = 8-bit address, 0 = 6-bit address |
| detect | input | 1 | 1 = choose the address width from word 0 first |
| div | input | 8 | Phase length minus one, in system clocks |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory shift clock |
| ee_di | output | 1 | Serial data into the memory |
| ee_do | input | 1 | Serial data out of the memory |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle pulse: `rdata` is valid |
| rdata | output | 16 | Last word read |
| width8 | output | 1 | Address width used by the last read (1 = 8 bits) |

## Verification
A start pulse is seen at the next clock edge, so `busy` rises one cycle after it. `ee_cs` then rises exactly `div`+1 cycles later. `busy` stays high for (`div`+1)·(46+2W) cycles per frame, and `done` and `rdata` appear in the first cycle after `busy` falls. The bench samples on the falling clock edge and counts busy cycles, preamble cycles and the length of every clock-high run. It compares these counts with the formulas above, not with fixed waits. It checks the result in the cycle `busy` is first low and checks that `done` has cleared one cycle later.

// File: rtl/ee_word_reader.sv
module ee_word_reader #(
  parameter int DIV_W = 8,
  parameter int NARROW_AW = 6,
  parameter int WIDE_AW = 8,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] SIGNATURE = 16'h8129
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDE_AW-1:0] addr,
  input  logic               wide,
  input  logic               detect,
  input  logic [DIV_W-1:0]   div,
  output logic               ee_cs,
  output logic               ee_sk,
  output logic               ee_di,
  input  logic               ee_do,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rdata,
  output logic               width8
);
  localparam int CMD_W = 5 + WIDE_AW;
  localparam int MAXN = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int CNT_W = $clog2(MAXN + 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SEL, S_CMD, S_GAP, S_DATA, S_FIN} st_t;

  st_t               st;
  logic [DIV_W-1:0]  div_q, tick;
  logic [WIDE_AW-1:0] addr_q;
  logic              wide_q, probe, hi;
  logic [CMD_W-1:0]  sr;
  logic [DATA_W-1:0] acc;
  logic [CNT_W-1:0]  left;

  wire ph_end = (tick == '0);
  wire last   = (left == CNT_W'(1));

  function automatic logic [CMD_W-1:0] mk_cmd(input logic [WIDE_AW-1:0] a, input logic w);
    logic [CMD_W-1:0] c;
    if (w)
      c = (CMD_W'(3'b110) << WIDE_AW) | CMD_W'(a);
    else
      c = ((CMD_W'(3'b110) << NARROW_AW) | CMD_W'(a[NARROW_AW-1:0])) << (WIDE_AW - NARROW_AW);
    return c;
  endfunction

  assign busy  = (st != S_IDLE);
  assign ee_cs = (st == S_SEL) || (st == S_CMD) || (st == S_GAP) || (st == S_DATA);
  assign ee_sk = hi && ((st == S_CMD) || (st == S_DATA));
  assign ee_di = (st == S_CMD) && sr[CMD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      div_q  <= '0;
      tick   <= '0;
      addr_q <= '0;
      wide_q <= 1'b0;
      probe  <= 1'b0;
      hi     <= 1'b0;
      sr     <= '0;
      acc    <= '0;
      left   <= '0;
      done   <= 1'b0;
      rdata  <= '0;
      width8 <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          addr_q <= addr;
          div_q  <= div;
          tick   <= div;
          probe  <= detect;
          wide_q <= detect | wide;
          sr     <= mk_cmd(detect ? '0 : addr, detect | wide);
          st     <= S_PRE;
        end
      end else if (!ph_end) begin
        tick <= tick - 1'b1;
      end else begin
        tick <= div_q;
        unique case (st)
          S_PRE: st <= S_SEL;
          S_SEL: begin
            st   <= S_CMD;
            hi   <= 1'b0;
            left <= wide_q ? CNT_W'(5 + WIDE_AW) : CNT_W'(5 + NARROW_AW);
          end
          S_CMD: begin
            if (!hi) hi <= 1'b1;
            else begin
              hi <= 1'b0;
              sr <= sr << 1;
              if (last) st <= S_GAP;
              else left <= left - 1'b1;
            end
          end
          S_GAP: begin
            st   <= S_DATA;
            left <= CNT_W'(DATA_W);
          end
          S_DATA: begin
            if (!hi) hi <= 1'b1;
            else begin
              hi  <= 1'b0;
              acc <= {acc[DATA_W-2:0], ee_do};
              if (last) st <= S_FIN;
              else left <= left - 1'b1;
            end
          end
          S_FIN: begin
            if (probe) begin
              probe  <= 1'b0;
              wide_q <= (acc == SIGNATURE);
              sr     <= mk_cmd(addr_q, acc == SIGNATURE);
              st     <= S_PRE;
            end else begin
              st     <= S_IDLE;
              done   <= 1'b1;
              rdata  <= acc;
              width8 <= wide_q;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_idle_cs_low_r7: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !ee_cs);
  p_sk_under_cs_r2: assert property (@(posedge clk) disable iff (!rst_n) ee_sk |-> ee_cs);
  p_di_held_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata != $past(rdata)) |-> done);
  p_frame_opens_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !ee_cs);
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !ph_end) |=> busy);
endmodule

// File: tb/ee_word_reader_tb_top.sv
module ee_word_reader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] addr = '0;
  logic wide = 1'b0;
  logic detect = 1'b0;
  logic [7:0] div = '0;
  logic ee_cs, ee_sk, ee_di, busy, done, width8;
  logic ee_do = 1'b0;
  logic [15:0] rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ee_word_reader dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .wide(wide),
    .detect(detect), .div(div), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do), .busy(busy), .done(done), .rdata(rdata), .width8(width8)
  );

  // memory model
  int resp_w = 8;
  logic [15:0] mem0 = 16'h0F0F;

  function automatic logic [15:0] word_of(input int a);
    logic [31:0] p;
    p = a * 32'h3B1D;
    return p[15:0] ^ 16'hC6A5;
  endfunction

  function automatic logic [15:0] mem_at(input int a);
    return (a == 0) ? mem0 : word_of(a);
  endfunction

  bit started;
  int k;
  logic [15:0] hdr, outw;
  logic [31:0] rx_log;
  int rx_n;

  always @(posedge ee_cs) begin
    started = 0; k = 0; hdr = '0; outw = '0; rx_log = '0; rx_n = 0; ee_do = 1'b0;
  end

  always @(posedge ee_sk) if (ee_cs) begin
    rx_log = {rx_log[30:0], ee_di};
    rx_n++;
    if (!started) started = ee_di;
    else if (k < 2 + resp_w) begin
      hdr = {hdr[14:0], ee_di};
      k++;
      if (k == 2 + resp_w) outw = mem_at(int'(hdr & 16'((1 << resp_w) - 1)));
    end else begin
      ee_do = outw[15];
      outw = outw << 1;
    end
  end

  // phase monitors
  int cur_div = 0;
  int hi_run = 0;
  int sk_bad = 0;
  int di_bad = 0;
  logic prev_sk = 1'b0, prev_di = 1'b0;
  always @(negedge clk) begin
    if (ee_sk) hi_run++;
    else begin
      if (hi_run != 0 && hi_run != cur_div + 1) sk_bad++;
      hi_run = 0;
    end
    if (ee_sk && prev_sk && ee_di != prev_di) di_bad++;
    prev_sk = ee_sk;
    prev_di = ee_di;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_read(input int a, input bit w, input bit det, input int dv,
                         input bit poke, input bit chk_data, input bit exp_w8);
    int n, pre, fw, exp_busy, exp_cmd;
    logic [15:0] exp_data;
    fw = det ? (exp_w8 ? 8 : 6) : (w ? 8 : 6);
    exp_busy = (dv + 1) * ((det ? 62 : 0) + 46 + 2 * fw);
    exp_cmd = (6 << fw) | (a & ((1 << fw) - 1));
    exp_data = mem_at(a & ((1 << fw) - 1));
    cur_div = dv;
    sk_bad = 0;
    di_bad = 0;
    @(negedge clk);
    addr = 8'(a); wide = w; detect = det; div = 8'(dv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0; pre = -1;
    while (busy && n < 150000) begin
      if (ee_cs && pre < 0) pre = n;
      n++;
      if (poke && n == 7) begin
        start = 1'b1; addr = ~addr; wide = ~wide; detect = ~detect; div = div + 8'd3;
      end else if (poke && n == 8) start = 1'b0;
      @(negedge clk);
    end
    chk(n == exp_busy, "R6 busy length", n, exp_busy);
    chk(pre == dv + 1, "R10 preamble", pre, dv + 1);
    chk(sk_bad == 0, "R6 clock high phase", sk_bad, 0);
    chk(di_bad == 0, "R2 data held while clock high", di_bad, 0);
    chk(done == 1'b1, "R9 done with busy low", int'(done), 1);
    chk(ee_cs == 1'b0, "R7 deselected", int'(ee_cs), 0);
    chk(width8 == exp_w8, det ? "R5 detected width" : "R4 width report", int'(width8), int'(exp_w8));
    if (chk_data) begin
      chk(rdata == exp_data, "R3 read word", int'(rdata), int'(exp_data));
      chk(rx_n == 21 + fw, "R2 clock count", rx_n, 21 + fw);
      chk((rx_log >> 16) == 32'(exp_cmd), "R2 command bits", int'(rx_log >> 16), exp_cmd);
    end
    @(negedge clk);
    chk(done == 1'b0, "R9 done pulse width", int'(done), 0);
    if (poke) chk(busy == 1'b0, "R8 second start ignored", int'(busy), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    chk({ee_cs, ee_sk, ee_di, busy, done, width8} == 6'b0, "R1 outputs in reset",
        int'({ee_cs, ee_sk, ee_di, busy, done, width8}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdata == 16'h0, "R1 rdata after reset", int'(rdata), 0);
    chk({ee_cs, busy, done} == 3'b0, "R1 idle after reset", int'({ee_cs, busy, done}), 0);

    // R4 narrow sweep
    resp_w = 6;
    for (int a = 0; a < 64; a++) do_read(a, 1'b0, 1'b0, 0, 1'b0, 1'b1, 1'b0);
    // R4 upper address bits ignored in narrow mode
    do_read(8'hC5, 1'b0, 1'b0, 0, 1'b0, 1'b1, 1'b0);
    do_read(8'h7F, 1'b0, 1'b0, 2, 1'b0, 1'b1, 1'b0);
    // wide sweep
    resp_w = 8;
    for (int a = 0; a < 256; a++) do_read(a, 1'b1, 1'b0, 0, 1'b0, 1'b1, 1'b1);
    // R6 divider sweep
    for (int d = 1; d < 6; d++) do_read(8'hA3 ^ d, 1'b1, 1'b0, d, 1'b0, 1'b1, 1'b1);
    do_read(8'h5C, 1'b1, 1'b0, 17, 1'b0, 1'b1, 1'b1);
    // R8 start and input changes while busy
    do_read(8'h3E, 1'b1, 1'b0, 1, 1'b1, 1'b1, 1'b1);
    resp_w = 6;
    do_read(8'h15, 1'b0, 1'b0, 0, 1'b1, 1'b1, 1'b0);
    // R5 detection: 8-bit part with signature
    resp_w = 8; mem0 = 16'h8129;
    do_read(8'h9A, 1'b0, 1'b1, 0, 1'b0, 1'b1, 1'b1);
    do_read(8'h00, 1'b0, 1'b1, 1, 1'b0, 1'b1, 1'b1);
    // R5 detection: 6-bit part
    resp_w = 6; mem0 = 16'h1234;
    do_read(8'h2B, 1'b1, 1'b1, 0, 1'b0, 1'b1, 1'b0);
    do_read(8'h3F, 1'b1, 1'b1, 2, 1'b0, 1'b1, 1'b0);
    // R5 detection: 8-bit part without signature picks 6
    resp_w = 8; mem0 = 16'h0000;
    do_read(8'h11, 1'b1, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    // R9 rdata holds while idle with moving inputs
    mem0 = 16'h0F0F;
    do_read(8'h44, 1'b1, 1'b0, 0, 1'b0, 1'b1, 1'b1);
    held = rdata;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      addr = 8'(i * 13); wide = i[0]; div = 8'(i);
    end
    chk(rdata == held, "R9 rdata holds", int'(rdata), int'(held));
    chk(busy == 1'b0 && ee_cs == 1'b0, "R7 stays deselected", int'({busy, ee_cs}), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule